// File: doc/BRIEF.md
# Dual-Polarity Capacitor Calibration Sequencer

This block runs foreground calibration of the six most significant capacitors of a split-array SAR DAC. Each capacitor is measured twice with opposite charge polarity. Each measurement has the same steps. First every plate is parked at mid-rail. Then the capacitor under test is charged against all lower capacitors. The top plate is released, then all bottom plates are released. Finally a 6-bit conversion runs on the lower half of the array, and the block reads back its signed result.

From the two signed results the block computes the mismatch of each capacitor in signed fixed point with one fractional bit. The difference of the two results cancels comparator offset. A running sum of the corrections already found for lower capacitors is added, so that their error is not counted twice. The block also averages the common-mode part of every measurement pair into one comparator-offset estimate. A start pulse begins the sequence, and busy and done report its progress. Seven result registers can be read by index. The analog array sits outside and is seen only through the conversion handshake.

Top module: `dpcal_engine`

## Requirements
- R1: After reset, busy_o and done_o are 0, top_hold_o and bot_hold_o are 1, every plate select is mid (code 00), and all seven readable registers return 0.
- R2: A start_i pulse while idle makes busy_o high on the next cycle; start_i while busy has no effect (the sequence still makes exactly 12 measurements).
- R3: Each measurement opens with SETTLE cycles where every plate select is mid and top_hold_o is 1.
- R4: In phase one, the plate pair of capacitor index LOW_CAPS+c (field plate_sel_o[2k+1:2k] for capacitor k) is ground (01), every lower capacitor is supply (10), and every higher one is mid (00).
- R5: In phase two, the polarities of R4 are swapped: the capacitor under test is supply (10) and lower capacitors are ground (01).
- R6: top_hold_o falls for one cycle while plates stay charged and bot_hold_o is 1. On the next cycle bot_hold_o falls, all selects return to mid, and conv_start_o pulses for exactly one cycle.
- R7: The block waits for conv_done_i for any number of cycles and takes conv_result_i in the cycle where conv_done_i is high.
- R8: Capacitors are measured in ascending order, c = 0 to 5, with phase one before phase two for each.
- R9: Register c (rd_idx_i = c) holds the net mismatch in half-LSB units: (p1 - p2) + the sum of the net mismatches of all lower capacitors.
- R10: Register 6 holds the offset estimate in half-LSB units: the sum over all capacitors of (p1 + p2), divided by 6 and truncated toward zero.
- R11: When the sequence ends, busy_o falls and done_o rises in the same cycle. done_o stays high until the next start, and busy_o and done_o are never both high.
- R12: A read index above 6 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a calibration sequence |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence complete, results valid |
| plate_sel_o | output | 26 | Two-bit bottom-plate select per capacitor: 00 mid, 01 ground, 10 supply |
| top_hold_o | output | 1 | 1 ties the top plate to mid-rail; its fall releases it |
| bot_hold_o | output | 1 | 1 keeps bottom plates on their selects; its fall returns them to mid |
| conv_start_o | output | 1 | One-cycle request for a lower-half conversion |
| conv_done_i | input | 1 | Conversion result valid |
| conv_result_i | input | 6 | Signed conversion result in LSB |
| rd_idx_i | input | 3 | Register index: 0-5 mismatch, 6 offset |
| rd_data_o | output | 13 | Signed selected register, one fractional bit |

## Verification
The bench uses the default parameters: seven lower capacitors, six calibrated capacitors, six-bit results and a three-cycle settle time. The short settle time lets several complete 12-measurement sequences run in a few thousand cycles. With six-bit results the bench can drive both ends of the signed range on every capacitor. Each measurement then doubles the running correction, so the net mismatch climbs to about half of the 13-bit register range, and the truncation of a negative offset average can be seen directly.

// File: rtl/dpcal_pkg.sv
package dpcal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DISCH,
        ST_CHARGE,
        ST_REL_TOP,
        ST_CONV
    } dpcal_st_e;

    localparam logic [1:0] PLATE_MID = 2'b00;
    localparam logic [1:0] PLATE_GND = 2'b01;
    localparam logic [1:0] PLATE_SUP = 2'b10;

endpackage

// File: rtl/dpcal_plate_drive.sv
module dpcal_plate_drive #(
    parameter int LOW_CAPS = 7,
    parameter int CAL_CAPS = 6,
    parameter int IDX_W    = 3,
    localparam int TOT_CAPS = LOW_CAPS + CAL_CAPS
) (
    input  logic                  charge_en,
    input  logic                  phase,
    input  logic [IDX_W-1:0]      cap_idx,
    output logic [2*TOT_CAPS-1:0] sel
);
    import dpcal_pkg::*;

    int tgt;
    assign tgt = LOW_CAPS + int'(cap_idx);

    for (genvar k = 0; k < TOT_CAPS; k++) begin : g_plate
        always_comb begin
            if (!charge_en) begin
                sel[2*k +: 2] = PLATE_MID;
            end else if (k == tgt) begin
                sel[2*k +: 2] = phase ? PLATE_SUP : PLATE_GND;
            end else if (k < tgt) begin
                sel[2*k +: 2] = phase ? PLATE_GND : PLATE_SUP;
            end else begin
                sel[2*k +: 2] = PLATE_MID;
            end
        end
    end

endmodule

// File: rtl/dpcal_math.sv
module dpcal_math #(
    parameter int RES_W = 6,
    parameter int ACC_W = 13,
    parameter int OS_W  = 11
) (
    input  logic signed [RES_W-1:0] p1,
    input  logic signed [RES_W-1:0] p2,
    input  logic signed [ACC_W-1:0] acc,
    output logic signed [ACC_W-1:0] net,
    output logic signed [ACC_W-1:0] acc_next,
    output logic signed [OS_W-1:0]  cm_term
);
    logic signed [RES_W:0] raw2;
    logic signed [RES_W:0] cm2;

    // half-LSB units: (p1-p2)/2 in Q.1 equals p1-p2 as an integer
    assign raw2     = RES_W'(p1) - RES_W'(p2) + (RES_W+1)'(0);
    assign cm2      = (RES_W+1)'(p1) + (RES_W+1)'(p2);
    assign net      = ACC_W'(raw2) + acc;
    assign acc_next = acc + net;
    assign cm_term  = OS_W'(cm2);

endmodule

// File: rtl/dpcal_engine.sv
module dpcal_engine #(
    parameter int LOW_CAPS = 7,
    parameter int CAL_CAPS = 6,
    parameter int RES_W    = 6,
    parameter int SETTLE   = 3,
    localparam int TOT_CAPS = LOW_CAPS + CAL_CAPS,
    localparam int IDX_W    = $clog2(CAL_CAPS + 1),
    localparam int ACC_W    = RES_W + 1 + CAL_CAPS,
    localparam int OS_W     = RES_W + 2 + $clog2(CAL_CAPS),
    localparam int CNT_W    = $clog2(SETTLE + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [2*TOT_CAPS-1:0]   plate_sel_o,
    output logic                    top_hold_o,
    output logic                    bot_hold_o,
    output logic                    conv_start_o,
    input  logic                    conv_done_i,
    input  logic signed [RES_W-1:0] conv_result_i,
    input  logic [IDX_W-1:0]        rd_idx_i,
    output logic signed [ACC_W-1:0] rd_data_o
);
    import dpcal_pkg::*;

    localparam logic signed [OS_W-1:0] N_DIV = OS_W'(CAL_CAPS);

    typedef struct packed {
        dpcal_st_e                      st;
        logic                           phase;
        logic [IDX_W-1:0]               cap;
        logic [CNT_W-1:0]               cnt;
        logic                           conv_go;
        logic                           done;
        logic [RES_W-1:0]               p1;
        logic [ACC_W-1:0]               acc;
        logic [OS_W-1:0]                osum;
        logic [CAL_CAPS-1:0][ACC_W-1:0] mis;
        logic [ACC_W-1:0]               off;
    } ctl_t;

    ctl_t q_q, q_d;

    logic                    charge_en;
    logic signed [ACC_W-1:0] net_w, acc_next_w;
    logic signed [OS_W-1:0]  cm_w, osum_tot, quot;

    dpcal_plate_drive #(
        .LOW_CAPS(LOW_CAPS), .CAL_CAPS(CAL_CAPS), .IDX_W(IDX_W)
    ) u_plate (
        .charge_en(charge_en), .phase(q_q.phase), .cap_idx(q_q.cap), .sel(plate_sel_o)
    );

    dpcal_math #(
        .RES_W(RES_W), .ACC_W(ACC_W), .OS_W(OS_W)
    ) u_math (
        .p1($signed(q_q.p1)), .p2(conv_result_i), .acc($signed(q_q.acc)),
        .net(net_w), .acc_next(acc_next_w), .cm_term(cm_w)
    );

    assign osum_tot = $signed(q_q.osum) + cm_w;
    assign quot     = osum_tot / N_DIV;

    always_comb begin
        q_d         = q_q;
        q_d.conv_go = 1'b0;
        case (q_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    q_d.st    = ST_DISCH;
                    q_d.phase = 1'b0;
                    q_d.cap   = '0;
                    q_d.cnt   = '0;
                    q_d.done  = 1'b0;
                    q_d.acc   = '0;
                    q_d.osum  = '0;
                end
            end
            ST_DISCH, ST_CHARGE: begin
                if (q_q.cnt == CNT_W'(SETTLE - 1)) begin
                    q_d.cnt = '0;
                    q_d.st  = (q_q.st == ST_DISCH) ? ST_CHARGE : ST_REL_TOP;
                end else begin
                    q_d.cnt = q_q.cnt + CNT_W'(1);
                end
            end
            ST_REL_TOP: begin
                q_d.st      = ST_CONV;
                q_d.conv_go = 1'b1;
            end
            ST_CONV: begin
                if (conv_done_i) begin
                    if (!q_q.phase) begin
                        q_d.p1    = conv_result_i;
                        q_d.phase = 1'b1;
                        q_d.st    = ST_DISCH;
                    end else begin
                        q_d.mis[q_q.cap] = net_w;
                        q_d.acc          = acc_next_w;
                        q_d.osum         = osum_tot;
                        q_d.phase        = 1'b0;
                        if (q_q.cap == IDX_W'(CAL_CAPS - 1)) begin
                            q_d.st   = ST_IDLE;
                            q_d.done = 1'b1;
                            q_d.off  = ACC_W'(quot);
                        end else begin
                            q_d.cap = q_q.cap + IDX_W'(1);
                            q_d.st  = ST_DISCH;
                        end
                    end
                end
            end
            default: q_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q    <= '0;
            q_q.st <= ST_IDLE;
        end else begin
            q_q <= q_d;
        end
    end

    assign busy_o       = (q_q.st != ST_IDLE);
    assign done_o       = q_q.done;
    assign top_hold_o   = (q_q.st == ST_IDLE) || (q_q.st == ST_DISCH) || (q_q.st == ST_CHARGE);
    assign bot_hold_o   = (q_q.st != ST_CONV);
    assign charge_en    = (q_q.st == ST_CHARGE) || (q_q.st == ST_REL_TOP);
    assign conv_start_o = q_q.conv_go;

    always_comb begin
        if (int'(rd_idx_i) < CAL_CAPS)       rd_data_o = $signed(q_q.mis[rd_idx_i]);
        else if (int'(rd_idx_i) == CAL_CAPS) rd_data_o = $signed(q_q.off);
        else                                 rd_data_o = '0;
    end

    logic [TOT_CAPS-1:0] gnd_v, sup_v;
    for (genvar k = 0; k < TOT_CAPS; k++) begin : g_pol
        assign gnd_v[k] = (plate_sel_o[2*k +: 2] == PLATE_GND);
        assign sup_v[k] = (plate_sel_o[2*k +: 2] == PLATE_SUP);
    end

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (plate_sel_o == '0 && top_hold_o && bot_hold_o)); // R1
    AST_CONV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o); // R6
    AST_CONV_PLATES_MID: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> (plate_sel_o == '0 && !top_hold_o && !bot_hold_o)); // R6
    AST_TOP_BEFORE_BOT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bot_hold_o) |-> $past(!top_hold_o && bot_hold_o)); // R6
    AST_SINGLE_GND_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (charge_en && !q_q.phase) |-> ($countones(gnd_v) == 1)); // R4
    AST_SINGLE_SUP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (charge_en && q_q.phase) |-> ($countones(sup_v) == 1)); // R5
    AST_CAP_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.cap != $past(q_q.cap)) |-> (q_q.cap == $past(q_q.cap) + IDX_W'(1) || q_q.cap == '0)); // R8

endmodule

// File: tb/sim_dpcal_engine.sv
module sim_dpcal_engine;
    localparam int LOW = 7, NC = 6, RW = 6, ST = 3, TOT = LOW + NC;

    logic clk = 0, rst_n = 0, start = 0, conv_done = 0;
    logic signed [RW-1:0] conv_res = '0;
    logic [2:0] rd_idx = '0;
    logic busy, done, top_hold, bot_hold, conv_start;
    logic [2*TOT-1:0] sel;
    logic signed [12:0] rd_data;

    always #5 clk = ~clk;

    dpcal_engine #(.LOW_CAPS(LOW), .CAL_CAPS(NC), .RES_W(RW), .SETTLE(ST)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
        .plate_sel_o(sel), .top_hold_o(top_hold), .bot_hold_o(bot_hold),
        .conv_start_o(conv_start), .conv_done_i(conv_done), .conv_result_i(conv_res),
        .rd_idx_i(rd_idx), .rd_data_o(rd_data));

    int n_chk = 0, n_bad = 0;
    int p1v[NC], p2v[NC];
    int lat_g = 3, resp_n = 0, wait_cnt = 0;
    int meas_n = 0, conv_n = 0, mid_run = 0;
    bit conv_ok = 1, prev_top = 1, prev_bot = 1;
    logic [2*TOT-1:0] prev_sel = '0;
    logic [2*TOT-1:0] rec_sel[16];
    int rec_mid[16];

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && top_hold && bot_hold && sel == '0) mid_run++;
            if (sel != '0 && prev_sel == '0 && top_hold && meas_n < 16) begin
                rec_mid[meas_n] = mid_run;
                mid_run = 0;
            end
            if (prev_top && !top_hold && meas_n < 16) begin
                rec_sel[meas_n] = sel;
                if (!bot_hold) conv_ok = 0;
                meas_n++;
            end
            if (conv_start) begin
                conv_n++;
                if (!(sel == '0 && !top_hold && !bot_hold && prev_bot && !prev_top)) conv_ok = 0;
            end
            prev_top = top_hold;
            prev_bot = bot_hold;
            prev_sel = sel;
        end
    end

    // conversion responder
    always @(negedge clk) begin
        conv_done = 0;
        if (wait_cnt > 0) begin
            wait_cnt--;
            if (wait_cnt == 0) begin
                conv_done = 1;
                conv_res = RW'(((resp_n % 2) == 0) ? p1v[(resp_n / 2) % NC] : p2v[(resp_n / 2) % NC]);
                resp_n++;
            end
        end
        if (conv_start) wait_cnt = lat_g;
    end

    function automatic logic [2*TOT-1:0] exp_sel(int m);
        logic [2*TOT-1:0] v = '0;
        int tgt = LOW + m / 2;
        bit ph = (m % 2) == 1;
        for (int k = 0; k < TOT; k++) begin
            if (k == tgt)     v[2*k +: 2] = ph ? 2'b10 : 2'b01;
            else if (k < tgt) v[2*k +: 2] = ph ? 2'b01 : 2'b10;
        end
        return v;
    endfunction

    task automatic t_reset();
        chk(busy == 0 && done == 0, "R1", "busy/done after reset", {busy, done}, 0);
        chk(top_hold && bot_hold, "R1", "holds after reset", {top_hold, bot_hold}, 3);
        chk(sel == '0, "R1", "plate selects after reset", int'(sel), 0);
        for (int i = 0; i <= NC; i++) begin
            rd_idx = 3'(i); #1;
            chk(rd_data == 0, "R1", $sformatf("register %0d after reset", i), int'(rd_data), 0);
        end
    endtask

    task automatic t_run(string name, int lat, bit poke);
        int acc = 0, s = 0, net, expo, cyc;
        resp_n = 0; meas_n = 0; conv_n = 0; conv_ok = 1; mid_run = 0; lat_g = lat;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        chk(busy == 1, "R2", {name, " busy after start"}, busy, 1);
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1; @(negedge clk) start = 0;     // R2: ignored while busy
        end
        cyc = 0;
        while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
        chk(done && !busy, "R11", {name, " done/busy at end"}, {done, busy}, 2);
        chk(meas_n == 2 * NC, "R2", {name, " measurement count"}, meas_n, 2 * NC);
        chk(conv_n == 2 * NC, "R7", {name, " conversion requests"}, conv_n, 2 * NC);
        chk(conv_ok, "R6", {name, " release order and conversion pulse"}, conv_ok, 1);
        for (int m = 0; m < 2 * NC && m < meas_n; m++) begin
            chk(rec_sel[m] == exp_sel(m), (m % 2) ? "R5" : "R4",
                $sformatf("%s selects meas %0d (R8 order)", name, m), int'(rec_sel[m]), int'(exp_sel(m)));
            chk(rec_mid[m] == ST, "R3", $sformatf("%s discharge meas %0d", name, m), rec_mid[m], ST);
        end
        for (int c = 0; c < NC; c++) begin
            net = (p1v[c] - p2v[c]) + acc;
            acc += net;
            s += p1v[c] + p2v[c];
            rd_idx = 3'(c); #1;
            chk(int'(rd_data) == net, "R9", $sformatf("%s mismatch %0d", name, c), int'(rd_data), net);
        end
        expo = s / NC;
        rd_idx = 3'(NC); #1;
        chk(int'(rd_data) == expo, "R10", {name, " offset"}, int'(rd_data), expo);
        repeat (4) @(negedge clk);
        chk(done == 1, "R11", {name, " done held"}, done, 1);
    endtask

    task automatic t_oob();
        rd_idx = 3'd7; #1;
        chk(rd_data == 0, "R12", "read index 7", int'(rd_data), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        p1v = '{-5, -5, -4, -4, -2, -13};
        p2v = '{-5, -4, -5, -5, -8, 4};
        t_run("table", 3, 0);
        p1v = '{-32, -32, -32, -32, -32, -32};
        p2v = '{31, 31, 31, 31, 31, 31};
        t_run("extremes", 1, 0);
        p1v = '{7, 7, 7, 7, 7, 8};
        p2v = '{7, 7, 7, 7, 7, 8};
        t_run("slow", 25, 1);
        t_oob();
        summary();
    end

    initial begin
        #1ms;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule